// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the thirty-two-bit general registers of a processor core in which the set of physical registers behind an architectural register number depends on the operating mode. Software always sees sixteen registers, numbered 0 to 15, where register 15 is the program counter. Some of those numbers are redirected to private copies when the core runs in a privileged exception mode. The fast-interrupt mode swaps out a wide group of registers. The other exception modes swap out only the stack pointer and link register. The unprivileged mode and the system mode share the base set.

The block has two combinational read ports and one write port, each addressed by a 4-bit architectural number. The mode used for the translation comes from a 5-bit input. A separate interface reads and writes the current status word. A third path reaches the saved-status copy that belongs to the current mode, and each exception mode has its own copy. Sequencing of exception entry and return, and incrementing the program counter, are done by the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: While reset is low and after it is released, every general register reads 0 in every mode, the status word reads 0x00000013 (supervisor encoding in bits 4:0), and every saved-status copy reads 0.
- R2: Mode codes 10000 (user) and 11111 (system) address one common set of registers 0 to 14 with no private copies.
- R3: Mode 10001 (fast interrupt) has private copies of registers 8 to 14. Its registers 0 to 7 are those of user mode.
- R4: Modes 10010 (interrupt), 10011 (supervisor), 10111 (abort) and 11011 (undefined) each have private copies of registers 13 and 14 only. Registers 0 to 12 in these modes are those of user mode.
- R5: Register 15 is one physical register that all modes share.
- R6: A read of a register in the same cycle as a write to it returns the old value. The new value is readable after the next rising clock edge. The status word behaves the same way.
- R7: Any mode code not listed in R2 to R4 selects the user register set and has no saved-status copy.
- R8: Each of the five exception modes in R3 and R4 has its own saved-status copy. A saved-status write in one of these modes changes only that mode's copy.
- R9: In user, system or an unlisted mode, a saved-status read returns the current status word, and a saved-status write changes no state.
- R10: A status word write is visible on the status read port after the next clock edge. The two read ports select registers independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 5 | Current processor mode code used for register translation |
| rd_a_sel | input | 4 | Architectural register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Architectural register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_sel | input | 4 | Architectural register number to write |
| wr_data | input | 32 | General register write data |
| stat_rdata | output | 32 | Current status word |
| stat_we | input | 1 | Status word write enable |
| stat_wdata | input | 32 | Status word write data |
| saved_rdata | output | 32 | Saved-status copy of the current mode |
| saved_we | input | 1 | Saved-status write enable |
| saved_wdata | input | 32 | Saved-status write data |

## Verification
The bench goes through all 32 mode codes. In each mode it writes every architectural register with a value that encodes the mode and register number. It then reads all 512 mode and register pairs on both ports. From the values returned, it can tell which writes landed in a shared register and which landed in a private copy, so a wrong bank boundary shows up as the wrong owner's pattern. Saved-status writes in all 32 codes separate the five private copies from the codes that must ignore the write. Same-cycle write and read on one register tells the old-value rule apart from a write that bypasses into the read.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  localparam int NUM_ARCH   = 16;
  localparam int FIQ_LO     = 8;
  localparam int FIQ_CNT    = 7;
  localparam int SMALL_LO   = 13;
  localparam int SMALL_CNT  = 2;
  localparam int SMALL_BANKS = 4;
  localparam int NUM_PHYS   = NUM_ARCH + FIQ_CNT + SMALL_BANKS * SMALL_CNT;
  localparam int NUM_SAVED  = 1 + SMALL_BANKS;
  localparam int PHYS_W     = $clog2(NUM_PHYS);
endpackage

// File: rtl/rfb_mode_decode.sv
module rfb_mode_decode
  import rfb_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_e      bank_o
);
  always_comb begin
    unique case (mode_i)
      MODE_FIQ: bank_o = BK_FIQ;
      MODE_IRQ: bank_o = BK_IRQ;
      MODE_SVC: bank_o = BK_SVC;
      MODE_ABT: bank_o = BK_ABT;
      MODE_UND: bank_o = BK_UND;
      default:  bank_o = BK_USR;
    endcase
  end
endmodule

// File: rtl/rfb_addr_map.sv
module rfb_addr_map
  import rfb_pkg::*;
(
  input  bank_e             bank_i,
  input  logic [3:0]        arch_i,
  output logic [PHYS_W-1:0] phys_o
);
  localparam int FIQ_BASE   = NUM_ARCH;
  localparam int SMALL_BASE = NUM_ARCH + FIQ_CNT;

  logic in_fiq_win;
  logic in_small_win;
  logic [2:0] small_slot;

  always_comb begin
    in_fiq_win   = (int'(arch_i) >= FIQ_LO) && (int'(arch_i) < FIQ_LO + FIQ_CNT);
    in_small_win = (int'(arch_i) >= SMALL_LO) && (int'(arch_i) < SMALL_LO + SMALL_CNT);
    small_slot   = 3'(bank_i) - 3'(BK_IRQ);
    if (bank_i == BK_FIQ && in_fiq_win) begin
      phys_o = PHYS_W'(FIQ_BASE + int'(arch_i) - FIQ_LO);
    end else if (bank_i != BK_USR && bank_i != BK_FIQ && in_small_win) begin
      phys_o = PHYS_W'(SMALL_BASE + int'(small_slot) * SMALL_CNT + int'(arch_i) - SMALL_LO);
    end else begin
      phys_o = PHYS_W'(arch_i);
    end
  end
endmodule

// File: rtl/rfb_saved_bank.sv
module rfb_saved_bank
  import rfb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int SLOT_W = $clog2(NUM_SAVED);

  logic [DATA_W-1:0] saved_q [NUM_SAVED];
  logic [SLOT_W-1:0] slot;
  logic              has_copy;

  always_comb begin
    has_copy = (bank_i != BK_USR);
    slot     = SLOT_W'(3'(bank_i) - 3'd1);
  end

  for (genvar i = 0; i < NUM_SAVED; i++) begin : g_saved
    logic              en;
    logic [DATA_W-1:0] d;
    always_comb begin
      en = we_i && has_copy && (slot == SLOT_W'(i));
      d  = en ? wdata_i : saved_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) saved_q[i] <= '0;
      else        saved_q[i] <= d;
    end
  end

  assign rdata_o = has_copy ? saved_q[slot] : stat_i;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rfb_pkg::*;
#(
  parameter int               DATA_W     = 32,
  parameter logic [DATA_W-1:0] STAT_RESET = DATA_W'(MODE_SVC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_sel,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_sel,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] stat_rdata,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] stat_wdata,
  output logic [DATA_W-1:0] saved_rdata,
  input  logic              saved_we,
  input  logic [DATA_W-1:0] saved_wdata
);
  bank_e             bank;
  logic [PHYS_W-1:0] phys_a;
  logic [PHYS_W-1:0] phys_b;
  logic [PHYS_W-1:0] phys_w;
  logic [DATA_W-1:0] phys_q [NUM_PHYS];
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] stat_d;

  rfb_mode_decode u_dec (.mode_i(mode_i), .bank_o(bank));

  rfb_addr_map u_map_a (.bank_i(bank), .arch_i(rd_a_sel), .phys_o(phys_a));
  rfb_addr_map u_map_b (.bank_i(bank), .arch_i(rd_b_sel), .phys_o(phys_b));
  rfb_addr_map u_map_w (.bank_i(bank), .arch_i(wr_sel),   .phys_o(phys_w));

  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] d;
    always_comb begin
      en = wr_en && (phys_w == PHYS_W'(i));
      d  = en ? wr_data : phys_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phys_q[i] <= '0;
      else        phys_q[i] <= d;
    end
  end

  always_comb begin
    stat_d = stat_we ? stat_wdata : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RESET;
    else        stat_q <= stat_d;
  end

  rfb_saved_bank #(.DATA_W(DATA_W)) u_saved (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank_i  (bank),
    .we_i    (saved_we),
    .wdata_i (saved_wdata),
    .stat_i  (stat_q),
    .rdata_o (saved_rdata)
  );

  assign rd_a_data  = phys_q[phys_a];
  assign rd_b_data  = phys_q[phys_b];
  assign stat_rdata = stat_q;
endmodule

// File: rtl/banked_regfile_checker.sv
module banked_regfile_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode_i,
  input logic [3:0]        rd_a_sel,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] stat_rdata,
  input logic              stat_we,
  input logic [DATA_W-1:0] stat_wdata,
  input logic [DATA_W-1:0] saved_rdata,
  input logic [DATA_W-1:0] pc_q
);
  assert_reset_status_R1: assert property (@(posedge clk)
    !rst_n |=> (stat_rdata == DATA_W'(5'b10011)));

  assert_pc_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 4'hF) |=> (pc_q == $past(wr_data)));

  assert_old_then_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_a_sel == wr_sel) |=>
      (!(rd_a_sel == $past(wr_sel) && mode_i == $past(mode_i)) || rd_a_data == $past(wr_data)));

  assert_saved_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 5'b10000 || mode_i == 5'b11111) |-> (saved_rdata == stat_rdata));

  assert_status_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> (stat_rdata == $past(stat_wdata)));
endmodule

bind banked_regfile banked_regfile_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .rd_a_sel    (rd_a_sel),
  .rd_a_data   (rd_a_data),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .stat_rdata  (stat_rdata),
  .stat_we     (stat_we),
  .stat_wdata  (stat_wdata),
  .saved_rdata (saved_rdata),
  .pc_q        (phys_q[15])
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic        clk;
  logic        rst_n;
  logic [4:0]  mode_i;
  logic [3:0]  rd_a_sel, rd_b_sel, wr_sel;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, stat_we, saved_we;
  logic [31:0] stat_rdata, stat_wdata, saved_rdata, saved_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_reg [6][16];
  logic [31:0] m_stat;
  logic [31:0] m_saved [6];

  banked_regfile uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stat_rdata(stat_rdata), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .saved_rdata(saved_rdata), .saved_we(saved_we), .saved_wdata(saved_wdata)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // bank owner of a mode code (R2, R3, R4, R7)
  function automatic int bank_of(int m);
    case (m)
      17: return 1;
      18: return 2;
      19: return 3;
      23: return 4;
      27: return 5;
      default: return 0;
    endcase
  endfunction

  // which bank's copy stands behind register r in bank b
  function automatic int owner(int b, int r);
    if (r == 15 || r < 8) return 0;
    if (b == 1) return 1;
    if (b >= 2 && r >= 13) return b;
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr_reg(int m, int r, logic [31:0] v);
    @(negedge clk);
    mode_i = 5'(m); wr_sel = 4'(r); wr_data = v; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
    m_reg[owner(bank_of(m), r)][r] = v;
  endtask

  task automatic sweep_read(string req);
    for (int m = 0; m < 32; m++) begin
      for (int r = 0; r < 16; r++) begin
        @(negedge clk);
        mode_i = 5'(m); rd_a_sel = 4'(r); rd_b_sel = 4'(r ^ 5);
        #1;
        chk(req, rd_a_data, m_reg[owner(bank_of(m), r)][r]);
        chk({req, " portB R10"}, rd_b_data, m_reg[owner(bank_of(m), r ^ 5)][r ^ 5]);
      end
    end
  endtask

  task automatic check_saved(string req);
    for (int m = 0; m < 32; m++) begin
      @(negedge clk);
      mode_i = 5'(m);
      #1;
      chk(req, saved_rdata, (bank_of(m) == 0) ? m_stat : m_saved[bank_of(m)]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 0; mode_i = 5'b10000; rd_a_sel = 0; rd_b_sel = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
    stat_we = 0; stat_wdata = 0; saved_we = 0; saved_wdata = 0;
    for (int b = 0; b < 6; b++) begin
      m_saved[b] = 0;
      for (int r = 0; r < 16; r++) m_reg[b][r] = 0;
    end
    m_stat = 32'h0000_0013;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status in reset", stat_rdata, 32'h13);
    chk("R1 regA in reset", rd_a_data, 32'h0);
    @(negedge clk);
    rst_n = 1;

    // R1: everything reads reset values in every mode
    sweep_read("R1 reset regs");
    check_saved("R1 reset saved");
    chk("R1 status", stat_rdata, 32'h13);

    // R2 R3 R4 R5 R7: write every register in every mode code, read all back
    for (int pass = 0; pass < 2; pass++) begin
      for (int m = 0; m < 32; m++)
        for (int r = 0; r < 16; r++)
          wr_reg(m, r, 32'hA500_0000 ^ (pass << 20) ^ (m << 8) ^ (r << 1) ^ 32'h1);
      sweep_read("R2 R3 R4 R5 R7 banking");
    end
    // reverse order changes which writes win on shared registers
    for (int m = 31; m >= 0; m--)
      for (int r = 15; r >= 0; r--)
        wr_reg(m, r, 32'h3C00_0000 ^ (m << 12) ^ (r << 4));
    sweep_read("R2 R3 R4 R5 R7 reverse");

    // R6: same-cycle write and read returns old value, new after edge
    for (int k = 0; k < 4; k++) begin
      int m;
      int r;
      logic [31:0] oldv;
      m = (k == 0) ? 19 : (k == 1) ? 17 : (k == 2) ? 16 : 27;
      r = (k == 0) ? 13 : (k == 1) ? 9 : (k == 2) ? 15 : 14;
      oldv = m_reg[owner(bank_of(m), r)][r];
      @(negedge clk);
      mode_i = 5'(m); rd_a_sel = 4'(r); wr_sel = 4'(r);
      wr_data = 32'hDEAD_0000 + k; wr_en = 1;
      #1;
      chk("R6 old value during write", rd_a_data, oldv);
      @(posedge clk); #1;
      wr_en = 0;
      m_reg[owner(bank_of(m), r)][r] = 32'hDEAD_0000 + k;
      chk("R6 new value after edge", rd_a_data, 32'hDEAD_0000 + k);
    end

    // R10 R6: status word write, old value during the write cycle
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      stat_wdata = 32'h6000_00C0 ^ (k << 16); stat_we = 1;
      #1;
      chk("R6 status old during write", stat_rdata, m_stat);
      @(posedge clk); #1;
      stat_we = 0;
      m_stat = 32'h6000_00C0 ^ (k << 16);
      chk("R10 status after write", stat_rdata, m_stat);
    end

    // R8 R9: saved-status write in all 32 mode codes
    for (int m = 0; m < 32; m++) begin
      @(negedge clk);
      mode_i = 5'(m); saved_wdata = 32'h5A00_0000 | (m << 4); saved_we = 1;
      @(posedge clk); #1;
      saved_we = 0;
      if (bank_of(m) != 0) m_saved[bank_of(m)] = 32'h5A00_0000 | (m << 4);
      chk("R8 R9 status untouched by saved write", stat_rdata, m_stat);
    end
    check_saved("R8 R9 saved copies");

    // R9: saved view follows status changes in user/system modes
    @(negedge clk);
    stat_wdata = 32'h0000_001F; stat_we = 1;
    @(posedge clk); #1;
    stat_we = 0;
    m_stat = 32'h0000_001F;
    check_saved("R9 saved mirrors status");

    // R1: asynchronous reset clears all state again
    @(negedge clk);
    rst_n = 0;
    #1;
    for (int b = 0; b < 6; b++) begin
      m_saved[b] = 0;
      for (int r = 0; r < 16; r++) m_reg[b][r] = 0;
    end
    m_stat = 32'h13;
    chk("R1 status on reset", stat_rdata, 32'h13);
    @(negedge clk);
    rst_n = 1;
    sweep_read("R1 regs after second reset");
    check_saved("R1 saved after second reset");

    report();
  end
endmodule